// File: doc/BRIEF.md
# Queue and Exception Interrupt Controller

This block merges three event sources into one registered, level-style interrupt line for a host. Two of the sources are the fill state of two work queues, one holding aged entries and one holding learned entries. Each arrives as a level that is high while its queue has at least one entry. The third source is a pair of write-exception pulses, one primary and one secondary. The queues and the exception detection are outside the block.

A queue source can interrupt only while it is armed. A source is armed at reset and in every cycle in which its queue is seen empty. Reading that queue's flag register disarms it. A queue that stays non-empty after the host has read its flags therefore stays silent until it drains and fills again. Exception pulses set sticky flags, and a read of the exception register clears them. The host can also read a combined status word without clearing anything. Each read returns the state as it was before that read cleared anything.

Top module: `qx_irq_ctrl`

## Requirements
- R1: `irq` is a register. It is high in the cycle after any cycle in which an armed queue is non-empty or an exception flag is (or becomes) set.
- R2: A read of address 0 disarms the aged source, and a read of address 1 disarms the learned source. A read of address 2 clears both exception flags. If no other source is active, `irq` is low after that read's clock edge.
- R3: A queue source is armed at reset and after every cycle in which its queue level is low, including a cycle in which its register is read. A queue that stays non-empty after its read does not raise `irq` again.
- R4: After a queue has been empty for at least one cycle, its next non-empty cycle raises `irq` one edge later.
- R5: An exception pulse sets its sticky flag and raises `irq` whatever the queue state is. A pulse in the same cycle as a read of address 2 is kept.
- R6: `rd_data` is loaded on the edge that ends a cycle with `rd_en` high, with the values as they were before that read. It holds its value while `rd_en` is low.
- R7: Address 0 (aged) and address 1 (learned) return bit 0 = pending (armed and non-empty) and bit 1 = queue non-empty level. All other bits are 0.
- R8: Address 2 returns bit 1 = primary exception flag and bit 0 = secondary exception flag. All other bits are 0.
- R9: Address 3 returns bit 29 = aged pending, bit 28 = learned pending, bit 27 = primary flag and bit 26 = secondary flag. All other bits are 0. Reading address 3 clears and disarms nothing.
- R10: While `rst_n` is low, `irq` and `rd_data` are 0 and both exception flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset; hold it low for at least 3 cycles |
| aged_ne | input | 1 | Aged queue holds at least one entry |
| learned_ne | input | 1 | Learned queue holds at least one entry |
| wex_pri | input | 1 | Primary write-exception pulse |
| wex_sec | input | 1 | Secondary write-exception pulse |
| rd_en | input | 1 | Host read strobe, one cycle per read |
| rd_addr | input | 2 | Register select (0 aged, 1 learned, 2 exceptions, 3 status) |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Registered interrupt level |

## Verification
Every result of this block is due exactly one rising edge after the cycle that causes it. This holds for `irq` responding to a level, a pulse or a read, and for `rd_data` capturing a read. A read's captured value reflects the state before that same edge. The bench drives each cycle's inputs on the falling edge and advances its reference model once per rising edge. It compares both outputs on the following falling edge, so each check lands in the one cycle where its result is due. Directed sequences cover drain-and-refill, reads while a queue is empty, and a pulse that coincides with an exception read. Seeded random cycles cover the rest.

// File: rtl/qx_pkg.sv
package qx_pkg;

    // Exception source indices inside the two-bit exception vector
    localparam int unsigned EXC_SEC = 0;
    localparam int unsigned EXC_PRI = 1;
    localparam int unsigned NUM_EXC = 2;

    // Lowest bit of the combined status field; the field order is decoded by host code
    localparam int unsigned STAT_BASE = 26;

    // Per-queue register layout
    localparam int unsigned QBIT_PEND = 0;
    localparam int unsigned QBIT_LVL  = 1;

    typedef struct packed {
        logic armed;
    } arm_state_t;

    typedef struct packed {
        logic [NUM_EXC-1:0] flags;
    } exc_state_t;

endpackage

// File: rtl/qx_queue_arm.sv
module qx_queue_arm
    import qx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ne_i,
    input  logic rd_clr_i,
    output logic pend_now_o,
    output logic pend_next_o
);

    arm_state_t st_d;
    arm_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (!ne_i) begin
            st_d.armed = 1'b1;
        end else if (rd_clr_i) begin
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{armed: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_now_o  = st_q.armed & ne_i;
    assign pend_next_o = st_d.armed & ne_i;

    AST_ARM_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !ne_i |=> st_q.armed); // R3

    AST_READ_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && ne_i) |=> !st_q.armed); // R2

    AST_ARM_ONLY_VIA_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.armed && ne_i) |=> !st_q.armed); // R3

endmodule

// File: rtl/qx_exc_flags.sv
module qx_exc_flags
    import qx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EXC-1:0] pulse_i,
    input  logic               rd_clr_i,
    output logic [NUM_EXC-1:0] flags_q_o,
    output logic [NUM_EXC-1:0] flags_d_o
);

    exc_state_t st_d;
    exc_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (rd_clr_i) begin
            st_d.flags = '0;
        end
        st_d.flags = st_d.flags | pulse_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_q_o = st_q.flags;
    assign flags_d_o = st_d.flags;

    genvar e;
    generate
        for (e = 0; e < NUM_EXC; e++) begin : g_chk
            AST_PULSE_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
                pulse_i[e] |=> st_q.flags[e]); // R5
            AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q.flags[e] && !rd_clr_i) |=> st_q.flags[e]); // R5
        end
    endgenerate

endmodule

// File: rtl/qx_reg_read.sv
module qx_reg_read
    import qx_pkg::*;
#(
    parameter int unsigned NUM_Q  = 2,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en_i,
    input  logic [ADDR_W-1:0]  rd_addr_i,
    input  logic [NUM_Q-1:0]   pend_i,
    input  logic [NUM_Q-1:0]   lvl_i,
    input  logic [NUM_EXC-1:0] exc_i,
    output logic [DATA_W-1:0]  rd_data_o
);

    localparam int unsigned ADDR_EXC  = NUM_Q;
    localparam int unsigned ADDR_STAT = NUM_Q + 1;
    localparam int unsigned QSTAT_LO  = STAT_BASE + NUM_EXC;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_state_t;

    rd_state_t         st_d;
    rd_state_t         st_q;
    logic [DATA_W-1:0] word;

    always_comb begin
        st_d = st_q;
        word = '0;
        for (int q = 0; q < NUM_Q; q++) begin
            if (rd_addr_i == ADDR_W'(q)) begin
                word[QBIT_PEND] = pend_i[q];
                word[QBIT_LVL]  = lvl_i[q];
            end
        end
        if (rd_addr_i == ADDR_W'(ADDR_EXC)) begin
            word[NUM_EXC-1:0] = exc_i;
        end
        if (rd_addr_i == ADDR_W'(ADDR_STAT)) begin
            word[STAT_BASE +: NUM_EXC] = exc_i;
            for (int q = 0; q < NUM_Q; q++) begin
                word[QSTAT_LO + NUM_Q - 1 - q] = pend_i[q];
            end
        end
        if (rd_en_i) begin
            st_d.rdata = word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data_o = st_q.rdata;

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rd_data_o)); // R6

endmodule

// File: rtl/qx_irq_ctrl.sv
module qx_irq_ctrl
    import qx_pkg::*;
#(
    parameter int unsigned NUM_Q  = 2,
    parameter int unsigned DATA_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        aged_ne,
    input  logic                        learned_ne,
    input  logic                        wex_pri,
    input  logic                        wex_sec,
    input  logic                        rd_en,
    input  logic [$clog2(NUM_Q+2)-1:0]  rd_addr,
    output logic [DATA_W-1:0]           rd_data,
    output logic                        irq
);

    localparam int unsigned ADDR_W   = $clog2(NUM_Q + 2);
    localparam int unsigned ADDR_EXC = NUM_Q;

    typedef struct packed {
        logic irq;
    } top_state_t;

    logic [NUM_Q-1:0]   q_lvl;
    logic [NUM_Q-1:0]   q_clr;
    logic [NUM_Q-1:0]   q_pend_now;
    logic [NUM_Q-1:0]   q_pend_next;
    logic [NUM_EXC-1:0] exc_pulse;
    logic [NUM_EXC-1:0] exc_q;
    logic [NUM_EXC-1:0] exc_d;
    logic               exc_clr;
    top_state_t         st_d;
    top_state_t         st_q;

    // Queue order: index 0 aged, index 1 learned; further queues are tied off empty
    always_comb begin
        q_lvl    = '0;
        q_lvl[0] = aged_ne;
        if (NUM_Q > 1) begin
            q_lvl[NUM_Q-1] = learned_ne;
        end
    end

    always_comb begin
        exc_pulse          = '0;
        exc_pulse[EXC_PRI] = wex_pri;
        exc_pulse[EXC_SEC] = wex_sec;
        exc_clr            = rd_en && (rd_addr == ADDR_W'(ADDR_EXC));
    end

    genvar q;
    generate
        for (q = 0; q < NUM_Q; q++) begin : g_queue
            assign q_clr[q] = rd_en && (rd_addr == ADDR_W'(q));
            qx_queue_arm u_arm (
                .clk         (clk),
                .rst_n       (rst_n),
                .ne_i        (q_lvl[q]),
                .rd_clr_i    (q_clr[q]),
                .pend_now_o  (q_pend_now[q]),
                .pend_next_o (q_pend_next[q])
            );
        end
    endgenerate

    qx_exc_flags u_exc (
        .clk       (clk),
        .rst_n     (rst_n),
        .pulse_i   (exc_pulse),
        .rd_clr_i  (exc_clr),
        .flags_q_o (exc_q),
        .flags_d_o (exc_d)
    );

    qx_reg_read #(
        .NUM_Q  (NUM_Q),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en_i   (rd_en),
        .rd_addr_i (rd_addr),
        .pend_i    (q_pend_now),
        .lvl_i     (q_lvl),
        .exc_i     (exc_q),
        .rd_data_o (rd_data)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = (|q_pend_next) | (|exc_d);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.irq;

    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(aged_ne || learned_ne || wex_pri || wex_sec || (|exc_q))); // R1

    AST_PULSE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (wex_pri || wex_sec) |=> irq); // R5

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!aged_ne && !learned_ne && !wex_pri && !wex_sec && (exc_q == '0)) |=> !irq); // R2

endmodule

// File: tb/qx_irq_ctrl_test.sv
module qx_irq_ctrl_test;

    localparam int CLK_PERIOD = 10;

    logic        clk;
    logic        rst_n;
    logic        aged_ne;
    logic        learned_ne;
    logic        wex_pri;
    logic        wex_sec;
    logic        rd_en;
    logic [1:0]  rd_addr;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // reference model state
    logic [1:0]  m_arm;
    logic        m_pri;
    logic        m_sec;
    logic        m_irq;
    logic [31:0] m_rd;

    qx_irq_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .aged_ne    (aged_ne),
        .learned_ne (learned_ne),
        .wex_pri    (wex_pri),
        .wex_sec    (wex_sec),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .irq        (irq)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [31:0] exp_word(input logic [1:0] a, input logic [1:0] pend,
                                             input logic [1:0] lvl, input logic p, input logic s);
        logic [31:0] w = '0;
        case (a)
            2'd0: begin w[0] = pend[0]; w[1] = lvl[0]; end        // R7
            2'd1: begin w[0] = pend[1]; w[1] = lvl[1]; end        // R7
            2'd2: begin w[1] = p; w[0] = s; end                   // R8
            default: begin                                        // R9
                w[29] = pend[0]; w[28] = pend[1]; w[27] = p; w[26] = s;
            end
        endcase
        return w;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic step(input logic ane, input logic lne, input logic pp, input logic sp,
                        input logic rd, input logic [1:0] a, input string tag);
        logic [1:0]  lvl;
        logic [1:0]  pend;
        logic [1:0]  n_arm;
        logic        n_pri;
        logic        n_sec;
        logic        clr_exc;
        string       rtag;
        lvl = {lne, ane};
        aged_ne = ane; learned_ne = lne; wex_pri = pp; wex_sec = sp;
        rd_en = rd; rd_addr = a;
        pend = m_arm & lvl;
        for (int q = 0; q < 2; q++) begin
            n_arm[q] = !lvl[q] ? 1'b1 : ((rd && a == 2'(q)) ? 1'b0 : m_arm[q]);
        end
        clr_exc = rd && (a == 2'd2);
        n_pri = (m_pri & !clr_exc) | pp;
        n_sec = (m_sec & !clr_exc) | sp;
        if (rd) m_rd = exp_word(a, pend, lvl, m_pri, m_sec);
        m_arm = n_arm; m_pri = n_pri; m_sec = n_sec;
        m_irq = (|(n_arm & lvl)) | n_pri | n_sec;
        @(posedge clk);
        @(negedge clk);
        check({tag, " irq"}, {31'b0, irq}, {31'b0, m_irq});
        if (!rd) rtag = "R6";
        else if (a == 2'd2) rtag = "R8";
        else if (a == 2'd3) rtag = "R9";
        else rtag = "R7";
        check({rtag, " rd_data"}, rd_data, m_rd);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        rst_n = 1'b0; aged_ne = 0; learned_ne = 0; wex_pri = 0; wex_sec = 0;
        rd_en = 0; rd_addr = 0;
        m_arm = 2'b11; m_pri = 0; m_sec = 0; m_irq = 0; m_rd = '0;
        repeat (4) @(negedge clk);
        check("R10 irq in reset", {31'b0, irq}, 32'd0);
        check("R10 rd_data in reset", rd_data, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: flags clear after reset, seen through the status view
        step(0, 0, 0, 0, 1, 2'd3, "R10");
        // R1: aged queue fills
        step(1, 0, 0, 0, 0, 2'd0, "R1");
        // R2: read aged clears irq
        step(1, 0, 0, 0, 1, 2'd0, "R2");
        // R3: stays non-empty, no re-raise
        step(1, 0, 0, 0, 0, 2'd0, "R3");
        step(1, 0, 0, 0, 0, 2'd0, "R3");
        // R4: drain and refill
        step(0, 0, 0, 0, 0, 2'd0, "R4");
        step(1, 0, 0, 0, 0, 2'd0, "R4");
        // R3: read while empty keeps the source armed
        step(1, 0, 0, 0, 1, 2'd0, "R2");
        step(0, 0, 0, 0, 1, 2'd0, "R3");
        step(1, 0, 0, 0, 0, 2'd0, "R3");
        step(1, 0, 0, 0, 1, 2'd0, "R2");
        // R5: exception raises irq while queue quiet
        step(1, 0, 1, 0, 0, 2'd0, "R5");
        // R5: pulse during exception read is kept
        step(1, 0, 0, 1, 1, 2'd2, "R5");
        step(1, 0, 0, 0, 1, 2'd3, "R9");
        step(1, 0, 0, 0, 1, 2'd2, "R5");
        step(1, 0, 0, 0, 0, 2'd0, "R2");
        // learned queue path, status read does not clear
        step(1, 1, 0, 0, 1, 2'd3, "R9");
        step(1, 1, 0, 0, 0, 2'd0, "R9");
        step(1, 1, 0, 0, 1, 2'd1, "R7");
        step(1, 1, 0, 0, 0, 2'd0, "R2");

        seed = 32'h5eed_1234;
        void'($urandom(seed));
        for (int i = 0; i < 3000; i++) begin
            logic ane;
            logic lne;
            logic rd;
            ane = ($urandom_range(9) == 0) ? !aged_ne : aged_ne;
            lne = ($urandom_range(9) == 0) ? !learned_ne : learned_ne;
            rd  = ($urandom_range(3) == 0);
            step(ane, lne, ($urandom_range(24) == 0), ($urandom_range(24) == 0),
                 rd, 2'($urandom_range(3)), "R1");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule